// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings an asynchronous DRAM out of power-up and keeps its contents alive. After reset it holds both strobes inactive for a programmable settling pause. It then runs a fixed number of wake-up strobe cycles on its own. Once those are done it raises `init_done` so the access controller may start working. From then on an interval timer adds one owed refresh every refresh period. Each owed refresh is settled by a single CAS-before-RAS cycle, which needs no address and leaves the data bus, write enable and output enable untouched.

The block shares the strobes with the access controller through a level request/grant pair. `ref_req` stays high from the moment a refresh is owed until the refresh cycle, including its closing precharge, has finished. A refresh is only launched on a cycle where `ref_grant` is high, so it never lands in the middle of an access. If the controller withholds the grant for so long that the owed count would pass its limit, the block pulses `deadline_miss`, drops `init_done`, clears the owed count and repeats the whole wake-up sequence. A refresh cycle that is already running when the miss occurs completes and counts toward the wake-up total. All times are parameters in clock cycles.

Top module: `dram_refresh_sequencer`

## Requirements
- R1: While reset is asserted: `ras_n`=1, `cas_n`=1, `init_done`=0, `ref_req`=0, `deadline_miss`=0 and `bus_own`=1.
- R2: After reset is released, the first RAS fall is seen after rising edge number PAUSE_CYC+CAS_PRE_CYC+CAS_SETUP_CYC+1, counting the first edge with reset released as number 1. `ref_grant` has no effect on this timing.
- R3: In every strobe cycle, CAS falls while RAS is high, after CAS has been high for at least CAS_PRE_CYC cycles. CAS is then low with RAS high for exactly CAS_SETUP_CYC cycles before RAS falls.
- R4: RAS stays low for exactly RAS_LOW_CYC cycles. CAS stays low for the first min(CAS_HOLD_CYC, RAS_LOW_CYC) of those cycles and is high for the rest.
- R5: Between two RAS low periods, RAS is high for at least RAS_PRE_CYC+CAS_PRE_CYC+CAS_SETUP_CYC cycles.
- R6: After the pause, `init_done` rises only once exactly WAKE_CNT RAS cycles have completed. These cycles need no grant.
- R7: When each request is served in time, `ref_req` rises REF_INTERVAL_CYC cycles after `init_done` rises, and again every REF_INTERVAL_CYC cycles after that.
- R8: During normal operation, RAS falls only while `ref_grant` is high. `ref_req` stays high until the refresh cycle ends. One grant yields exactly one refresh cycle. A grant that arrives while no request is raised has no effect on the strobes.
- R9: If the grant is withheld while a request is pending, `deadline_miss` pulses for one cycle DEBT_LIMIT*REF_INTERVAL_CYC cycles after `ref_req` rose. `init_done` falls in the same cycle.
- R10: After a missed deadline, exactly WAKE_CNT RAS cycles run before `init_done` rises again. The owed count starts from zero, so the next request comes REF_INTERVAL_CYC cycles after `init_done` rises.
- R11: `bus_own` is high whenever RAS or CAS is low and throughout the pause and the wake-up cycles. It is low while the block is ready and not refreshing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_grant | input | 1 | Level grant from the access controller |
| ref_req | output | 1 | Refresh owed or in progress; request for the strobes |
| bus_own | output | 1 | This block drives the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| init_done | output | 1 | Pause and wake-up done; accesses are allowed |
| deadline_miss | output | 1 | One-cycle pulse when the owed refresh limit is passed |

## Verification
The bench builds the block with a 40-cycle pause, 4 wake-up cycles, a 60-cycle refresh period, a debt limit of 3, and strobe phases of 2/1/4/3 cycles with a 2-cycle CAS hold. These short values fit power-up, many refresh periods, a forced deadline miss with its full re-wake, and a mid-run reset into one short run. The split CAS hold inside the RAS low window exercises the variant where CAS is released early, and the spacing of requests, strobe edges and the miss pulse is measured against cycle counts taken from the requirements.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

   typedef enum logic [1:0] {
      SQ_PAUSE   = 2'd0,
      SQ_WAKE    = 2'd1,
      SQ_READY   = 2'd2,
      SQ_REFRESH = 2'd3
   } seq_state_e;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_CPRE = 3'd1,
      PH_CSET = 3'd2,
      PH_RLOW = 3'd3,
      PH_RPRE = 3'd4
   } cbr_phase_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
   parameter int unsigned INTERVAL_CYC = 1560
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int unsigned CW = $clog2(INTERVAL_CYC);
   localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

   logic [CW-1:0] cnt;

   initial assert (INTERVAL_CYC >= 2);

   assign tick = run && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (!run || tick) cnt <= '0;
      else                   cnt <= cnt + 1'b1;
   end

   // R7: ticks are separated by a full interval
   a_r7_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/rfsh_debt_counter.sv
module rfsh_debt_counter #(
   parameter int unsigned DEBT_LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic add,
   input  logic sub,
   output logic pending,
   output logic overflow
);
   localparam int unsigned DW = $clog2(DEBT_LIMIT + 1);
   localparam logic [DW-1:0] LIM = DW'(DEBT_LIMIT);

   logic [DW-1:0] owed;

   initial assert (DEBT_LIMIT >= 1);

   assign pending  = (owed != '0);
   assign overflow = add && !sub && (owed == LIM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   owed <= '0;
      else if (clear || overflow)   owed <= '0;
      else if (add && !sub)         owed <= owed + 1'b1;
      else if (sub && !add)         owed <= owed - 1'b1;
   end

   // R9: owed count never passes its limit
   a_r9_debt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      owed <= LIM);
   // R8: a refresh is only retired when one is owed
   a_r8_no_retire_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (sub && !add) |-> pending);

endmodule

// File: rtl/cbr_cycle_engine.sv
module cbr_cycle_engine
   import dram_rfsh_pkg::*;
#(
   parameter int unsigned CAS_PRE_CYC   = 1,
   parameter int unsigned CAS_SETUP_CYC = 1,
   parameter int unsigned RAS_LOW_CYC   = 7,
   parameter int unsigned CAS_HOLD_CYC  = 1,
   parameter int unsigned RAS_PRE_CYC   = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done,
   output logic ras_n,
   output logic cas_n
);
   localparam int unsigned MAX_PH = max2(max2(CAS_PRE_CYC, CAS_SETUP_CYC),
                                         max2(RAS_LOW_CYC, RAS_PRE_CYC));
   localparam int unsigned CW = $clog2(MAX_PH + 1);
   localparam logic [CW-1:0] LD_CPRE = CW'(CAS_PRE_CYC - 1);
   localparam logic [CW-1:0] LD_CSET = CW'(CAS_SETUP_CYC - 1);
   localparam logic [CW-1:0] LD_RLOW = CW'(RAS_LOW_CYC - 1);
   localparam logic [CW-1:0] LD_RPRE = CW'(RAS_PRE_CYC - 1);

   cbr_phase_e    phase;
   logic [CW-1:0] cnt;
   logic          cnt_zero;
   logic          rlow_cas;

   initial begin
      assert (CAS_PRE_CYC   >= 1);
      assert (CAS_SETUP_CYC >= 1);
      assert (RAS_LOW_CYC   >= 1);
      assert (CAS_HOLD_CYC  >= 1);
      assert (RAS_PRE_CYC   >= 1);
   end

   assign cnt_zero = (cnt == '0);
   assign busy     = (phase != PH_IDLE);
   assign done     = (phase == PH_RPRE) && cnt_zero;

   generate
      if (CAS_HOLD_CYC >= RAS_LOW_CYC) begin : g_hold_full
         assign rlow_cas = 1'b1;
      end else begin : g_hold_part
         localparam logic [CW-1:0] REL = CW'(RAS_LOW_CYC - CAS_HOLD_CYC);
         assign rlow_cas = (cnt >= REL);
      end
   endgenerate

   assign ras_n = (phase != PH_RLOW);
   assign cas_n = !((phase == PH_CSET) || ((phase == PH_RLOW) && rlow_cas));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: if (start) begin phase <= PH_CPRE; cnt <= LD_CPRE; end
            PH_CPRE: if (cnt_zero) begin phase <= PH_CSET; cnt <= LD_CSET; end
                     else cnt <= cnt - 1'b1;
            PH_CSET: if (cnt_zero) begin phase <= PH_RLOW; cnt <= LD_RLOW; end
                     else cnt <= cnt - 1'b1;
            PH_RLOW: if (cnt_zero) begin phase <= PH_RPRE; cnt <= LD_RPRE; end
                     else cnt <= cnt - 1'b1;
            PH_RPRE: if (cnt_zero) begin phase <= PH_IDLE; cnt <= '0; end
                     else cnt <= cnt - 1'b1;
            default: begin phase <= PH_IDLE; cnt <= '0; end
         endcase
      end
   end

   // R3: CAS already low in the cycle before RAS falls
   a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (!cas_n && $past(!cas_n)));
   // R3: CAS only falls while RAS is high
   a_r3_cas_falls_ras_high: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |-> ras_n);
   // R8: a new cycle is never requested on top of a running one
   a_r8_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

endmodule

// File: rtl/dram_refresh_sequencer.sv
module dram_refresh_sequencer
   import dram_rfsh_pkg::*;
#(
   parameter int unsigned PAUSE_CYC        = 20000,
   parameter int unsigned WAKE_CNT         = 8,
   parameter int unsigned REF_INTERVAL_CYC = 1560,
   parameter int unsigned CAS_PRE_CYC      = 1,
   parameter int unsigned CAS_SETUP_CYC    = 1,
   parameter int unsigned RAS_LOW_CYC      = 7,
   parameter int unsigned CAS_HOLD_CYC     = 1,
   parameter int unsigned RAS_PRE_CYC      = 5,
   parameter int unsigned DEBT_LIMIT       = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_grant,
   output logic ref_req,
   output logic bus_own,
   output logic ras_n,
   output logic cas_n,
   output logic init_done,
   output logic deadline_miss
);
   localparam int unsigned PW = $clog2(PAUSE_CYC);
   localparam int unsigned WW = $clog2(WAKE_CNT + 1);
   localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);
   localparam logic [WW-1:0] WAKE_LOAD  = WW'(WAKE_CNT);

   seq_state_e    state;
   logic [PW-1:0] pause_cnt;
   logic [WW-1:0] wake_left;
   logic          tick, pending, overflow, retire;
   logic          eng_start, eng_busy, eng_done;
   logic          timer_run;

   initial begin
      assert (PAUSE_CYC >= 2);
      assert (WAKE_CNT  >= 1);
   end

   assign init_done = (state == SQ_READY) || (state == SQ_REFRESH);
   assign timer_run = init_done;
   assign bus_own   = (state != SQ_READY);
   assign ref_req   = ((state == SQ_READY) && pending) || (state == SQ_REFRESH);
   assign retire    = (state == SQ_REFRESH) && eng_done && !overflow;
   assign eng_start = ((state == SQ_WAKE) && !eng_busy) ||
                      ((state == SQ_READY) && pending && ref_grant && !overflow);

   rfsh_interval_timer #(.INTERVAL_CYC(REF_INTERVAL_CYC)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (timer_run),
      .tick (tick)
   );

   rfsh_debt_counter #(.DEBT_LIMIT(DEBT_LIMIT)) u_debt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (!init_done),
      .add     (tick),
      .sub     (retire),
      .pending (pending),
      .overflow(overflow)
   );

   cbr_cycle_engine #(
      .CAS_PRE_CYC  (CAS_PRE_CYC),
      .CAS_SETUP_CYC(CAS_SETUP_CYC),
      .RAS_LOW_CYC  (RAS_LOW_CYC),
      .CAS_HOLD_CYC (CAS_HOLD_CYC),
      .RAS_PRE_CYC  (RAS_PRE_CYC)
   ) u_engine (
      .clk  (clk),
      .rst_n(rst_n),
      .start(eng_start),
      .busy (eng_busy),
      .done (eng_done),
      .ras_n(ras_n),
      .cas_n(cas_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= SQ_PAUSE;
         pause_cnt     <= '0;
         wake_left     <= '0;
         deadline_miss <= 1'b0;
      end else begin
         deadline_miss <= overflow;
         unique case (state)
            SQ_PAUSE: begin
               if (pause_cnt == PAUSE_LAST) begin
                  state     <= SQ_WAKE;
                  wake_left <= WAKE_LOAD;
               end else begin
                  pause_cnt <= pause_cnt + 1'b1;
               end
            end
            SQ_WAKE: begin
               if (eng_done) begin
                  if (wake_left == WW'(1)) state <= SQ_READY;
                  wake_left <= wake_left - 1'b1;
               end
            end
            SQ_READY: begin
               if (overflow) begin
                  state     <= SQ_WAKE;
                  wake_left <= WAKE_LOAD;
               end else if (pending && ref_grant) begin
                  state <= SQ_REFRESH;
               end
            end
            SQ_REFRESH: begin
               if (overflow) begin
                  state     <= SQ_WAKE;
                  wake_left <= WAKE_LOAD;
               end else if (eng_done) begin
                  state <= SQ_READY;
               end
            end
            default: state <= SQ_PAUSE;
         endcase
      end
   end

   // R8: requests only once ready
   a_r8_req_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
      ref_req |-> init_done);
   // R9: the miss pulse coincides with loss of readiness
   a_r9_miss_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
      deadline_miss |-> !init_done);
   // R9: the miss pulse lasts one cycle
   a_r9_miss_single: assert property (@(posedge clk) disable iff (!rst_n)
      deadline_miss |=> !deadline_miss);
   // R11: strobes are only active while the block owns them
   a_r11_strobes_owned: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n || !cas_n) |-> bus_own);

endmodule

// File: tb/sim_dram_refresh_sequencer.sv
module sim_dram_refresh_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int PAUSE  = 40;
   localparam int WAKE   = 4;
   localparam int INTV   = 60;
   localparam int CPRE   = 2;
   localparam int CSET   = 1;
   localparam int RLOW   = 4;
   localparam int CHOLD  = 2;
   localparam int RPRE   = 3;
   localparam int LIMIT  = 3;
   localparam int EXP_FIRST = PAUSE + CPRE + CSET + 1;
   localparam int MIN_GAP   = RPRE + CPRE + CSET;
   localparam int CHOLD_EFF = (CHOLD < RLOW) ? CHOLD : RLOW;
   localparam int NV = 5;
   // each row: {cycles grant is withheld after request, cycles of grant pulse before request}
   localparam int VEC [NV][2] = '{'{0, 0}, '{3, 4}, '{7, 0}, '{15, 2}, '{30, 6}};

   logic clk = 1'b0;
   logic rst_n;
   logic ref_grant;
   logic ref_req, bus_own, ras_n, cas_n, init_done, deadline_miss;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dram_refresh_sequencer #(
      .PAUSE_CYC(PAUSE), .WAKE_CNT(WAKE), .REF_INTERVAL_CYC(INTV),
      .CAS_PRE_CYC(CPRE), .CAS_SETUP_CYC(CSET), .RAS_LOW_CYC(RLOW),
      .CAS_HOLD_CYC(CHOLD), .RAS_PRE_CYC(RPRE), .DEBT_LIMIT(LIMIT)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .ref_grant(ref_grant), .ref_req(ref_req),
      .bus_own(bus_own), .ras_n(ras_n), .cas_n(cas_n),
      .init_done(init_done), .deadline_miss(deadline_miss)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   // monitor state
   bit prev_ras, prev_cas, prev_init, prev_req, first_seen, miss_seen;
   int ras_high_run, ras_low_run, cas_low_run, cas_high_run, cas_in_ras;
   int falls, falls_since, anchor, req_rise, misses;

   always @(negedge clk) begin
      if (!rst_n) begin
         prev_ras = 1; prev_cas = 1; prev_init = 0; prev_req = 0; first_seen = 0;
         ras_high_run = 0; ras_low_run = 0; cas_low_run = 0; cas_high_run = 0;
         cas_in_ras = 0; falls_since = 0; anchor = 0; req_rise = 0;
      end else begin
         if (prev_ras && !ras_n) begin
            chk(!cas_n && cas_low_run == CSET, "R3 cas setup before ras fall", cas_low_run, CSET);
            chk(bus_own, "R11 own at ras fall", bus_own, 1);
            chk(!init_done || ref_grant, "R8 ras fell without grant", ref_grant, 1);
            if (!first_seen) chk(cyc == EXP_FIRST, "R2 first ras fall edge", cyc, EXP_FIRST);
            else chk(ras_high_run >= MIN_GAP, "R5 ras precharge", ras_high_run, MIN_GAP);
            first_seen = 1; falls++; falls_since++; ras_low_run = 0; cas_in_ras = 0;
         end
         if (!prev_ras && ras_n) begin
            chk(ras_low_run == RLOW, "R4 ras low width", ras_low_run, RLOW);
            chk(cas_in_ras == CHOLD_EFF, "R4 cas hold in ras low", cas_in_ras, CHOLD_EFF);
            if (init_done) chk(ref_req, "R8 request held through cycle", ref_req, 1);
            ras_high_run = 0;
         end
         if (prev_cas && !cas_n)
            chk(ras_n && cas_high_run >= CPRE, "R3 cas precharge before fall", cas_high_run, CPRE);
         if (!init_done && !bus_own) chk(0, "R11 own during init", bus_own, 1);
         if (init_done && !prev_init) begin
            chk(falls_since == WAKE, miss_seen ? "R10 wake count after miss" : "R6 wake count",
                falls_since, WAKE);
            anchor = cyc;
         end
         if (!init_done && prev_init) falls_since = 0;
         if (ref_req && !prev_req) begin
            chk(cyc - anchor == INTV, miss_seen ? "R10 request spacing" : "R7 request spacing",
                cyc - anchor, INTV);
            anchor = cyc; req_rise = cyc;
         end
         if (deadline_miss) begin
            chk(!init_done && prev_init, "R9 ready drops with miss", init_done, 0);
            chk(cyc - req_rise == LIMIT * INTV, "R9 miss timing", cyc - req_rise, LIMIT * INTV);
            misses++; miss_seen = 1;
         end
         if (ras_n) ras_high_run++;
         else begin ras_low_run++; if (!cas_n) cas_in_ras++; end
         if (cas_n) begin cas_low_run = 0; cas_high_run++; end
         else begin cas_high_run = 0; if (ras_n) cas_low_run++; end
         prev_ras = ras_n; prev_cas = cas_n; prev_init = init_done; prev_req = ref_req;
      end
   end

   task automatic serve_one();
      while (!ref_req) @(negedge clk);
      ref_grant = 1;
      while (ref_req) @(negedge clk);
      ref_grant = 0;
   endtask

   initial begin
      int f0;
      rst_n = 0; ref_grant = 0;
      repeat (3) @(negedge clk);
      chk(ras_n && cas_n, "R1 strobes idle in reset", {ras_n, cas_n}, 3);
      chk(!init_done, "R1 init_done low in reset", init_done, 0);
      chk(!ref_req, "R1 no request in reset", ref_req, 0);
      chk(!deadline_miss, "R1 no miss in reset", deadline_miss, 0);
      chk(bus_own, "R1 own in reset", bus_own, 1);
      ref_grant = 1;                  // grant during pause must change nothing (R2)
      rst_n = 1;
      while (!init_done) @(negedge clk);
      ref_grant = 0;
      @(negedge clk);
      chk(!bus_own, "R11 bus released when ready", bus_own, 0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][1] > 0) begin
            ref_grant = 1;
            for (int k = 0; k < VEC[i][1]; k++) begin
               @(negedge clk);
               chk(ras_n && cas_n, "R8 grant without request ignored", {ras_n, cas_n}, 3);
            end
            ref_grant = 0;
         end
         while (!ref_req) @(negedge clk);
         f0 = falls;
         for (int k = 0; k < VEC[i][0]; k++) begin
            @(negedge clk);
            chk(ras_n && ref_req, "R8 waits for grant", ras_n, 1);
         end
         ref_grant = 1;
         while (ref_req) @(negedge clk);
         ref_grant = 0;
         @(negedge clk);
         chk(falls == f0 + 1, "R8 one refresh per grant", falls, f0 + 1);
      end

      // missed deadline: request left unanswered
      while (!ref_req) @(negedge clk);
      while (!deadline_miss) @(negedge clk);
      chk(!init_done && ras_n, "R9 miss state", init_done, 0);
      @(negedge clk);
      chk(!deadline_miss, "R9 miss is one cycle", deadline_miss, 0);
      while (!init_done) @(negedge clk);
      serve_one();
      chk(misses == 1, "R9 exactly one miss", misses, 1);

      // reset in mid operation
      @(negedge clk);
      rst_n = 0;
      @(negedge clk);
      chk(ras_n && cas_n && !init_done && !ref_req && bus_own, "R1 mid-run reset",
          {ras_n, cas_n, init_done, ref_req, bus_own}, 5'b11001);
      rst_n = 1;
      while (!init_done) @(negedge clk);
      serve_one();
      @(negedge clk);
      chk(misses == 1 && !bus_own, "R11 ready after second start", misses, 1);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule